// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver with Parity Generation and Checking

This block joins two 9-bit buses, called A and B. Each word on either bus holds eight data bits in positions 7:0 and one parity bit in position 8. Words from A travel toward B through one latch, and words from B travel toward A through a second latch. On the way out, the parity bit is either recomputed from the latched data bits or copied unchanged from the latched parity bit. A single sense input selects odd or even parity. That setting applies to the generators and to the two checkers.

Each tri-state bus pin is split into three signals: an input word, an output word and an output-drive strobe. The surrounding pad logic does the real three-stating. Each bus has an active-low drive request. If both requests are asserted together, the block drives neither bus and raises a conflict flag.

Each latch is modelled as a level-controlled word. While its open input is high, the word follows the bus. While the open input is low, it keeps what it stored at the last clock edge where open was high. Both stored words are cleared at reset.

Top module: `xcvr_parity_link`

## Requirements
- R1: With `drv_b_n`=0 and `drv_a_n`=1, `b_oe`=1 and `a_oe`=0. With `drv_a_n`=0 and `drv_b_n`=1, `a_oe`=1 and `b_oe`=0. With both requests high, neither strobe is set and `conflict`=0.
- R2: With both `drv_a_n` and `drv_b_n` low, `a_oe`=0, `b_oe`=0 and `conflict`=1.
- R3: While `cap_a` is high, `b_out[7:0]` equals the live `a_in[7:0]`. While `cap_b` is high, `a_out[7:0]` equals the live `b_in[7:0]`.
- R4: While an open input is low, the outgoing data bits keep the word stored at the last rising clock edge at which that open input was high. Changes on the source bus have no effect on them.
- R5: With `par_pass`=0, the outgoing bit 8 is generated so that the nine outgoing bits together have the parity set by `odd_sense`.
- R6: With `par_pass`=1, the outgoing bit 8 equals the latched source parity bit 8.
- R7: While a latch is closed, the generated parity is computed from the stored data and not from the live bus.
- R8: `odd_sense`=1 means a good word holds an odd number of ones. `odd_sense`=0 means a good word holds an even number of ones.
- R9: `bad_a_n` and `bad_b_n` are active low. Each goes low when the 9-bit word in its bus's latch (the live word when open, the stored word when closed) violates the selected parity.
- R10: After reset, with both latches closed, both stored words are zero. With `par_pass`=1, `a_out` and `b_out` then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the latch storage |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 9 | Word received from bus A (bit 8 parity) |
| a_out | output | 9 | Word presented to bus A |
| a_oe | output | 1 | Drive strobe for bus A pads |
| b_in | input | 9 | Word received from bus B (bit 8 parity) |
| b_out | output | 9 | Word presented to bus B |
| b_oe | output | 1 | Drive strobe for bus B pads |
| drv_a_n | input | 1 | Active-low request to drive bus A |
| drv_b_n | input | 1 | Active-low request to drive bus B |
| cap_a | input | 1 | Open (1) or close (0) the latch fed by bus A |
| cap_b | input | 1 | Open (1) or close (0) the latch fed by bus B |
| par_pass | input | 1 | 0: generate outgoing parity, 1: pass parity through |
| odd_sense | input | 1 | 1: odd parity, 0: even parity |
| bad_a_n | output | 1 | Active-low parity error on the bus A word |
| bad_b_n | output | 1 | Active-low parity error on the bus B word |
| conflict | output | 1 | Both buses were requested to drive at once |

## Verification
Both directions are swept over every 8-bit data value, under both incoming parity bits, both parity senses and both parity-bit modes. This sweep separates generation from pass-through, shows that the odd and even senses are not swapped, and shows whether each error flag reports its own bus. Hold sequences store a word, then drive a different live word whose parity error status is the opposite. This shows whether the outgoing data, the generated parity and the error flag come from the stored word or from the bus. All four drive-request combinations are applied to confirm the strobe decoding and the conflict case.

// File: rtl/xcvr_pkg.sv
// Shared types and helpers for the parity transceiver.
// Assumes parity words are data bits plus one parity bit on top.
package xcvr_pkg;

    // Drive decision for the two buses.
    typedef enum logic [1:0] {
        DRV_NONE  = 2'd0,
        DRV_A     = 2'd1,
        DRV_B     = 2'd2,
        DRV_CLASH = 2'd3
    } drive_e;

    // Parity bit that brings a word with reduction-XOR x to the wanted sense.
    function automatic logic fill_bit(input logic x, input logic odd);
        return x ^ odd;
    endfunction

endpackage

// File: rtl/word_latch.sv
// Level-controlled word store emulated with a register.
// While open_i is high the output follows d_i. Otherwise it shows the value
// captured at the last clock edge with open_i high. Cleared by reset.
module word_latch #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] held;

    // Capture the input while the latch is open.
    always_ff @(posedge clk) begin
        if (!rst_n)      held <= '0;
        else if (open_i) held <= d_i;
    end

    // Transparent bypass while open, stored word otherwise.
    always_comb q_o = open_i ? d_i : held;
endmodule

// File: rtl/xcvr_lane.sv
// One direction of the transceiver: latch, parity generator, parity
// select and checker for the source bus. Assumes the parity bit is the MSB.
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        open_i,
    input  logic [DW:0] src_i,
    input  logic        par_pass,
    input  logic        odd_sense,
    output logic [DW:0] word_o,
    output logic        bad_n
);
    localparam int W = DW + 1;

    logic [W-1:0] latched;
    logic         gen_par;

    word_latch #(.W(W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (open_i),
        .d_i    (src_i),
        .q_o    (latched)
    );

    // Generated parity from the latched data bits.
    always_comb gen_par = fill_bit(^latched[DW-1:0], odd_sense);

    // Outgoing word: latched data with generated or passed parity.
    always_comb word_o = {par_pass ? latched[DW] : gen_par, latched[DW-1:0]};

    // Source bus check on the latched word, active low.
    always_comb bad_n = ((^latched) == odd_sense);
endmodule

// File: rtl/xcvr_parity_link.sv
// Bidirectional 9-bit latched transceiver with parity generate/check.
// Lane 0 carries A to B, lane 1 carries B to A. Drive requests are active
// low; requesting both drives neither bus and flags a conflict.
module xcvr_parity_link
    import xcvr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [DW:0] a_in,
    output logic [DW:0] a_out,
    output logic        a_oe,
    input  logic [DW:0] b_in,
    output logic [DW:0] b_out,
    output logic        b_oe,
    input  logic        drv_a_n,
    input  logic        drv_b_n,
    input  logic        cap_a,
    input  logic        cap_b,
    input  logic        par_pass,
    input  logic        odd_sense,
    output logic        bad_a_n,
    output logic        bad_b_n,
    output logic        conflict
);
    localparam int W     = DW + 1;
    localparam int LANES = 2;

    logic [W-1:0] src_v  [LANES];
    logic [W-1:0] dst_v  [LANES];
    logic         open_v [LANES];
    logic         bad_v  [LANES];
    drive_e       drive;

    assign src_v[0]  = a_in;
    assign src_v[1]  = b_in;
    assign open_v[0] = cap_a;
    assign open_v[1] = cap_b;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xcvr_lane #(.DW(DW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_i    (open_v[g]),
            .src_i     (src_v[g]),
            .par_pass  (par_pass),
            .odd_sense (odd_sense),
            .word_o    (dst_v[g]),
            .bad_n     (bad_v[g])
        );
    end

    assign b_out   = dst_v[0];
    assign a_out   = dst_v[1];
    assign bad_a_n = bad_v[0];
    assign bad_b_n = bad_v[1];

    // Decode the two active-low drive requests.
    always_comb begin
        unique case ({drv_a_n, drv_b_n})
            2'b11:   drive = DRV_NONE;
            2'b01:   drive = DRV_A;
            2'b10:   drive = DRV_B;
            default: drive = DRV_CLASH;
        endcase
    end

    // Pad strobes and conflict flag from the decision.
    always_comb begin
        a_oe     = (drive == DRV_A);
        b_oe     = (drive == DRV_B);
        conflict = (drive == DRV_CLASH);
    end
endmodule

// File: rtl/xcvr_parity_chk.sv
// Assertion checker for xcvr_parity_link, attached with bind.
module xcvr_parity_chk #(
    parameter int DW = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic [DW:0] a_in,
    input logic [DW:0] a_out,
    input logic        a_oe,
    input logic [DW:0] b_in,
    input logic [DW:0] b_out,
    input logic        b_oe,
    input logic        cap_a,
    input logic        cap_b,
    input logic        par_pass,
    input logic        odd_sense,
    input logic        bad_a_n,
    input logic        conflict
);
    // R1
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));
    // R2
    clash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (!a_oe && !b_oe));
    // R3
    a_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a |-> (b_out[DW-1:0] == a_in[DW-1:0]));
    // R3
    b_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_b |-> (a_out[DW-1:0] == b_in[DW-1:0]));
    // R4
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_a && $past(!cap_a)) |-> $stable(b_out[DW-1:0]));
    // R5
    gen_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_pass |-> ((^b_out) == odd_sense));
    // R6
    pass_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_pass && cap_a) |-> (b_out[DW] == a_in[DW]));
    // R9
    a_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a |-> (bad_a_n == ((^a_in) == odd_sense)));
endmodule

bind xcvr_parity_link xcvr_parity_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_in      (a_in),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_in      (b_in),
    .b_out     (b_out),
    .b_oe      (b_oe),
    .cap_a     (cap_a),
    .cap_b     (cap_b),
    .par_pass  (par_pass),
    .odd_sense (odd_sense),
    .bad_a_n   (bad_a_n),
    .conflict  (conflict)
);

// File: tb/tb_xcvr_parity_link.sv
module tb_xcvr_parity_link;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] a_in = '0, b_in = '0;
    logic [8:0] a_out, b_out;
    logic       a_oe, b_oe, bad_a_n, bad_b_n, conflict;
    logic       drv_a_n = 1'b1, drv_b_n = 1'b1;
    logic       cap_a = 1'b0, cap_b = 1'b0;
    logic       par_pass = 1'b1, odd_sense = 1'b0;
    int         checks = 0, errors = 0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    xcvr_parity_link dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .drv_a_n(drv_a_n), .drv_b_n(drv_b_n),
        .cap_a(cap_a), .cap_b(cap_b),
        .par_pass(par_pass), .odd_sense(odd_sense),
        .bad_a_n(bad_a_n), .bad_b_n(bad_b_n), .conflict(conflict)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int ones8(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // Expected outgoing parity bit and error flag, computed arithmetically.
    function automatic logic exp_par(input int d, input int p, input int s, input int pass);
        if (pass != 0) return p[0];
        return ((ones8(d) + s) % 2) == 1;
    endfunction

    function automatic logic exp_ok(input int d, input int p, input int s);
        return ((ones8(d) + p) % 2) == s;
    endfunction

    // Sweep one direction: dir 0 is A to B, dir 1 is B to A.
    task automatic sweep(input int dir);
        for (int s = 0; s < 2; s++)
            for (int pass = 0; pass < 2; pass++)
                for (int p = 0; p < 2; p++)
                    for (int d = 0; d < 256; d++) begin
                        odd_sense = s[0];
                        par_pass  = pass[0];
                        if (dir == 0) a_in = 9'(p * 256 + d);
                        else          b_in = 9'(p * 256 + d);
                        #1;
                        if (dir == 0) begin
                            check(pass != 0 ? "R6 R3 a->b word" : "R5 R8 R3 a->b word",
                                  b_out, {exp_par(d, p, s, pass), 8'(d)});
                            check("R9 R8 bad_a_n", {8'd0, bad_a_n}, {8'd0, exp_ok(d, p, s)});
                        end else begin
                            check(pass != 0 ? "R6 R3 b->a word" : "R5 R8 R3 b->a word",
                                  a_out, {exp_par(d, p, s, pass), 8'(d)});
                            check("R9 R8 bad_b_n", {8'd0, bad_b_n}, {8'd0, exp_ok(d, p, s)});
                        end
                    end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R10: cleared stored words, pass-through parity, even sense
        check("R10 a_out after reset", a_out, 9'h000);
        check("R10 b_out after reset", b_out, 9'h000);
        check("R10 flags after reset", {7'd0, bad_a_n, bad_b_n}, 9'h003);
        // R1 / R2: drive request decoding
        check("R1 idle strobes", {6'd0, a_oe, b_oe, conflict}, 9'h000);
        drv_b_n = 1'b0; #1;
        check("R1 drive B", {6'd0, a_oe, b_oe, conflict}, 9'h002);
        drv_b_n = 1'b1; drv_a_n = 1'b0; #1;
        check("R1 drive A", {6'd0, a_oe, b_oe, conflict}, 9'h004);
        drv_b_n = 1'b0; #1;
        check("R2 both requested", {6'd0, a_oe, b_oe, conflict}, 9'h001);
        drv_a_n = 1'b1;

        // R3 R5 R6 R8 R9: exhaustive sweeps both ways
        cap_a = 1'b1; sweep(0); cap_a = 1'b0;
        drv_b_n = 1'b1; drv_a_n = 1'b0;
        cap_b = 1'b1; sweep(1); cap_b = 1'b0;
        drv_a_n = 1'b1; drv_b_n = 1'b0;

        // R4 R7 R9: hold a good word, live word bad
        @(negedge clk);
        odd_sense = 1'b1; par_pass = 1'b0;
        cap_a = 1'b1; a_in = 9'h007;
        @(negedge clk);
        cap_a = 1'b0; a_in = 9'h0FF;
        #1;
        check("R4 R7 held word generated parity", b_out, 9'h007);
        check("R9 held good word", {8'd0, bad_a_n}, 9'h001);
        @(negedge clk); #1;
        check("R4 still held next cycle", b_out, 9'h007);
        par_pass = 1'b1; #1;
        check("R6 held parity passed", b_out, 9'h007);

        // R9 R7: hold a bad word, live word good
        par_pass = 1'b0;
        @(negedge clk);
        cap_a = 1'b1; a_in = 9'h003;
        @(negedge clk);
        cap_a = 1'b0; a_in = 9'h001;
        #1;
        check("R9 held bad word", {8'd0, bad_a_n}, 9'h000);
        check("R7 generated from stored 03", b_out, 9'h103);

        // R4 on B to A path
        @(negedge clk);
        cap_b = 1'b1; b_in = 9'h1A5;
        @(negedge clk);
        cap_b = 1'b0; b_in = 9'h05A;
        #1;
        check("R4 b->a held data", {1'b0, a_out[7:0]}, 9'h0A5);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule